// File: doc/BRIEF.md
# DMA Channel Counting Semaphore

This block holds an 8-bit unsigned counting semaphore for one DMA channel. It keeps the software program stream and a descriptor-chain engine in step. Software raises the count by writing an increment value into the low byte of a 32-bit register. The DMA engine asks to take one unit each time it finishes a command that needs one. While the count is zero, the engine's request is refused and the channel stalls. It stays stalled until software adds to the count.

The update is atomic within one clock. A software add and a DMA take may arrive on the same clock. The add is applied first, with saturation at 255. The take is then judged against that sum. Both results merge into a single net change of the count. The grant and stall outputs follow from the request in the same cycle, so a held request goes through in the first cycle in which the count, including any add in that cycle, is non-zero.

The register reads back the live count in bits 23:16. Every other bit reads as zero, so the increment field is write-only in effect. A debug port shows the count and a sticky flag that is set when an add saturated.

Top module: `chan_sema_top`

## Requirements
- R1: A synchronous active-high reset sets the count to 0, clears the overflow flag, and holds grant and stall at 0 while it is asserted.
- R2: A register write with no take pending adds the unsigned value in write bits 7:0 to the count, and the new count is visible from the next cycle.
- R3: A take request while the count is non-zero is granted in the same cycle with stall low, and the count is one lower from the next cycle.
- R4: A take request while the count is zero and no add occurs in that cycle gives grant 0 and stall 1, and the count stays at zero.
- R5: When an add and a take request fall on the same clock, the add is applied first and the take is judged on the sum. The count ends at sum minus one; for example, an add of 2 with a take gives a net gain of 1, and a take at count zero with an add of 1 is granted and leaves zero.
- R6: The register read value carries the count in bits 23:16, and bits 31:24, 15:8 and 7:0 read as zero at all times.
- R7: Write bits 31:8 are ignored: only bits 7:0 change the count.
- R8: A write with an increment of 0 leaves the count unchanged.
- R9: An add whose sum passes 255 leaves the count at 255 before any same-cycle take. It also sets the overflow flag, which stays set until reset.
- R10: A take request held through a stall is granted in the first cycle in which the count, including any add in that cycle, is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Write data; bits 7:0 hold the increment |
| reg_rd_data | output | 32 | Read data; count in bits 23:16, zeros elsewhere |
| take_req | input | 1 | DMA engine asks to take one unit |
| take_grant | output | 1 | The take is accepted in this cycle |
| take_stall | output | 1 | The take is refused in this cycle; the engine must wait |
| dbg_count | output | 8 | Current count |
| dbg_ovf | output | 1 | Sticky flag: an add has saturated at 255 |

## Verification
The count is exercised with adds alone, takes alone, and both on the same clock. These patterns separate an add-then-take order from a take-then-add order, and from a design that drops one of two colliding updates. Takes at zero, with and without an add in the same cycle, separate a correct stall from a count that wraps to 255 and from a grant that lags by a cycle. Adds near 255 show whether the count saturates or wraps, and writes with only the upper bits set show whether the reserved bits are ignored. A long random sequence with frequent collisions is then compared, cycle by cycle, with a reference model kept in the bench.

// File: rtl/chan_sema_pkg.sv
package chan_sema_pkg;

  localparam int SEMA_CNT_W   = 8;
  localparam int SEMA_REG_W   = 32;
  localparam int SEMA_INC_LSB = 0;
  localparam int SEMA_CNT_LSB = 16;

  // Outcome of one cycle of the take handshake.
  typedef enum logic [1:0] {
    TAKE_IDLE  = 2'b00,
    TAKE_GRANT = 2'b01,
    TAKE_STALL = 2'b10
  } take_state_e;

endpackage

// File: rtl/sema_sat_adder.sv
module sema_sat_adder #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cur_count,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  output logic [CNT_W-1:0] sum_count,
  output logic             saturated
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Wide sum, so that a carry out of the count width shows as saturation.
  function automatic logic [CNT_W:0] wide_sum(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [CNT_W:0] raw_sum;

  always_comb begin
    raw_sum   = wide_sum(cur_count, add_en ? add_val : '0);
    saturated = raw_sum[CNT_W];
    sum_count = saturated ? CNT_MAX : raw_sum[CNT_W-1:0];
  end

  // R9: the clamped sum never falls below the starting count
  always_comb begin
    assert_sum_monotonic_R9: assert (sum_count >= cur_count);
  end

endmodule

// File: rtl/sema_take_arb.sv
module sema_take_arb #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]              avail,
  input  logic                          req,
  output chan_sema_pkg::take_state_e    state,
  output logic [CNT_W-1:0]              next_count
);
  import chan_sema_pkg::*;

  function automatic take_state_e judge(input logic [CNT_W-1:0] a, input logic r);
    if (!r)            return TAKE_IDLE;
    else if (a == '0)  return TAKE_STALL;
    else               return TAKE_GRANT;
  endfunction

  always_comb begin
    state      = judge(avail, req);
    next_count = (state == TAKE_GRANT) ? avail - 1'b1 : avail;
  end

  // R3/R4: a grant and a stall never come together, and a request always gets one of them
  always_comb begin
    assert_outcome_onehot_R4: assert (!req || state == TAKE_GRANT || state == TAKE_STALL);
  end

endmodule

// File: rtl/sema_reg_view.sv
module sema_reg_view #(
  parameter int REG_W   = 32,
  parameter int CNT_W   = 8,
  parameter int CNT_LSB = 16
) (
  input  logic [CNT_W-1:0] count,
  output logic [REG_W-1:0] rd_data
);

  localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b >= CNT_LSB && b <= CNT_MSB) begin : g_cnt
      assign rd_data[b] = count[b - CNT_LSB];
    end else begin : g_zero
      assign rd_data[b] = 1'b0;
    end
  end

  // R6: the count field carries the count and the rest is empty
  always_comb begin
    assert_view_field_R6: assert (rd_data[CNT_MSB:CNT_LSB] == count);
    assert_view_zero_R6:  assert ((rd_data & ~({{(REG_W-CNT_W){1'b0}}, {CNT_W{1'b1}}} << CNT_LSB)) == '0);
  end

endmodule

// File: rtl/chan_sema_top.sv
module chan_sema_top #(
  parameter int REG_W   = chan_sema_pkg::SEMA_REG_W,
  parameter int CNT_W   = chan_sema_pkg::SEMA_CNT_W,
  parameter int INC_LSB = chan_sema_pkg::SEMA_INC_LSB,
  parameter int CNT_LSB = chan_sema_pkg::SEMA_CNT_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             take_req,
  output logic             take_grant,
  output logic             take_stall,
  output logic [CNT_W-1:0] dbg_count,
  output logic             dbg_ovf
);
  import chan_sema_pkg::*;

  localparam int INC_MSB = INC_LSB + CNT_W - 1;

  logic [CNT_W-1:0] count_q;
  logic             ovf_q;
  logic [CNT_W-1:0] inc_val;
  logic [CNT_W-1:0] after_add;
  logic             add_sat;
  logic [CNT_W-1:0] count_d;
  take_state_e      take_state;

  // Named events for the checks below.
  logic             ev_add;
  logic             ev_grant;
  logic             ev_stall;

  // Only the increment field is used; the other write bits are dropped.
  logic [REG_W-1:0] unused_wr_bits;
  assign unused_wr_bits = reg_wr_data & ~({{(REG_W-CNT_W){1'b0}}, {CNT_W{1'b1}}} << INC_LSB);
  assign inc_val        = reg_wr_data[INC_MSB:INC_LSB];

  sema_sat_adder #(.CNT_W(CNT_W)) u_add (
    .cur_count (count_q),
    .add_en    (reg_wr_en),
    .add_val   (inc_val),
    .sum_count (after_add),
    .saturated (add_sat)
  );

  sema_take_arb #(.CNT_W(CNT_W)) u_arb (
    .avail      (after_add),
    .req        (take_req & ~rst),
    .state      (take_state),
    .next_count (count_d)
  );

  sema_reg_view #(.REG_W(REG_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)) u_view (
    .count   (count_q),
    .rd_data (reg_rd_data)
  );

  assign ev_add   = reg_wr_en;
  assign ev_grant = (take_state == TAKE_GRANT);
  assign ev_stall = (take_state == TAKE_STALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      if (add_sat) ovf_q <= 1'b1;
    end
  end

  assign take_grant = ev_grant;
  assign take_stall = ev_stall;
  assign dbg_count  = count_q;
  assign dbg_ovf    = ovf_q;

  // R1: nothing is granted or stalled during reset
  always_comb begin
    if (rst) assert_reset_quiet_R1: assert (!take_grant && !take_stall);
  end

  // R1: reset empties the count and the flag
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (count_q == '0 && !ovf_q));

  // R3: a take without an add removes exactly one unit
  assert_take_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_grant && !ev_add) |=> count_q == $past(count_q) - 1'b1);

  // R4: a take at zero without an add stalls
  assert_zero_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (take_req && !ev_add && count_q == '0) |-> (take_stall && !take_grant));

  // R4: a stall leaves the count where it was
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ev_stall |=> $stable(count_q));

  // R5: an add of one with a take at zero is granted
  assert_collide_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (take_req && ev_add && inc_val != '0) |-> take_grant);

  // R8: with no add and no grant the count holds
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!ev_add && !ev_grant) |=> $stable(count_q));

  // R9: the overflow flag stays set
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);

  // R10: a request is stalled only when the count is empty
  assert_no_overflow_stall_R10: assert property (@(posedge clk) disable iff (rst)
    take_stall |-> (count_q == '0));

endmodule

// File: tb/test_chan_sema_top.sv
module test_chan_sema_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        take_req = 1'b0;
  logic        take_grant;
  logic        take_stall;
  logic [7:0]  dbg_count;
  logic        dbg_ovf;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int  m_cnt = 0;
  bit  m_ovf = 1'b0;

  always #4 clk = ~clk;

  chan_sema_top i_chan_sema_top (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .take_req    (take_req),
    .take_grant  (take_grant),
    .take_stall  (take_stall),
    .dbg_count   (dbg_count),
    .dbg_ovf     (dbg_ovf)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // One clock: drive at negedge, check handshake mid-cycle, check state after the edge.
  task automatic step(input string tag, input bit wr, input logic [31:0] data, input bit req);
    int  sum;
    bit  exp_g;
    @(negedge clk);
    reg_wr_en   = wr;
    reg_wr_data = data;
    take_req    = req;
    sum = m_cnt + (wr ? int'(data[7:0]) : 0);
    if (sum > 255) begin
      sum   = 255;
      m_ovf = 1'b1;
    end
    exp_g = req && (sum != 0);
    #1;
    check({tag, " grant"}, int'(take_grant), int'(exp_g));
    check({tag, " stall"}, int'(take_stall), int'(req && !exp_g));
    @(posedge clk);
    m_cnt = sum - (exp_g ? 1 : 0);
    #1;
    reg_wr_en = 1'b0;
    take_req  = 1'b0;
    check({tag, " count"}, int'(dbg_count), m_cnt);
    check({tag, " ovf"}, int'(dbg_ovf), int'(m_ovf));
    check({tag, " readback R6"}, int'(reg_rd_data), m_cnt << 16);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    take_req = 1'b1;
    #1;
    check("R1 grant in reset", int'(take_grant), 0);
    check("R1 stall in reset", int'(take_stall), 0);
    @(posedge clk);
    #1;
    take_req = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0;
    m_ovf = 1'b0;
    check("R1 count after reset", int'(dbg_count), 0);
    check("R1 ovf after reset", int'(dbg_ovf), 0);
  endtask

  task automatic t_add();
    do_reset();
    step("R2 add 5", 1'b1, 32'h0000_0005, 1'b0);
    step("R2 add 3", 1'b1, 32'h0000_0003, 1'b0);
    check("R2 total", int'(dbg_count), 8);
    step("R8 add zero", 1'b1, 32'h0000_0000, 1'b0);
    check("R8 unchanged", int'(dbg_count), 8);
  endtask

  task automatic t_take();
    do_reset();
    step("R3 preload", 1'b1, 32'h0000_0002, 1'b0);
    step("R3 take", 1'b0, 32'h0, 1'b1);
    step("R3 take", 1'b0, 32'h0, 1'b1);
    check("R3 emptied", int'(dbg_count), 0);
    step("R4 take at zero", 1'b0, 32'h0, 1'b1);
    step("R4 again at zero", 1'b0, 32'h0, 1'b1);
    check("R4 no wrap", int'(dbg_count), 0);
  endtask

  task automatic t_collide();
    do_reset();
    step("R5 preload", 1'b1, 32'h0000_0004, 1'b0);
    step("R5 add 2 with take", 1'b1, 32'h0000_0002, 1'b1);
    check("R5 net plus one", int'(dbg_count), 5);
    do_reset();
    step("R5 add 1 at zero with take", 1'b1, 32'h0000_0001, 1'b1);
    check("R5 zero after collide", int'(dbg_count), 0);
  endtask

  task automatic t_reserved();
    do_reset();
    step("R7 upper bits only", 1'b1, 32'hFFFF_FF00, 1'b0);
    check("R7 count untouched", int'(dbg_count), 0);
    step("R7 mixed bits", 1'b1, 32'hA5A5_5A07, 1'b0);
    check("R7 low byte only", int'(dbg_count), 7);
  endtask

  task automatic t_saturate();
    do_reset();
    step("R9 load 250", 1'b1, 32'h0000_00FA, 1'b0);
    check("R9 no flag yet", int'(dbg_ovf), 0);
    step("R9 load 5 to 255", 1'b1, 32'h0000_0005, 1'b0);
    check("R9 exact max no flag", int'(dbg_ovf), 0);
    step("R9 overflow add", 1'b1, 32'h0000_0010, 1'b0);
    check("R9 clamp", int'(dbg_count), 255);
    check("R9 flag set", int'(dbg_ovf), 1);
    step("R9 overflow with take", 1'b1, 32'h0000_0003, 1'b1);
    check("R9 clamp then take", int'(dbg_count), 254);
    step("R9 sticky", 1'b0, 32'h0, 1'b1);
    check("R9 flag kept", int'(dbg_ovf), 1);
  endtask

  task automatic t_stall_release();
    do_reset();
    step("R10 stalled 1", 1'b0, 32'h0, 1'b1);
    step("R10 stalled 2", 1'b0, 32'h0, 1'b1);
    step("R10 released by add", 1'b1, 32'h0000_0003, 1'b1);
    check("R10 after release", int'(dbg_count), 2);
    step("R10 next take", 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 600; i++) begin
      bit          wr  = ($urandom_range(0, 2) == 0);
      bit          req = ($urandom_range(0, 1) == 1);
      logic [31:0] d   = $urandom;
      if ($urandom_range(0, 7) != 0) d[7:0] = 8'($urandom_range(0, 3));
      step("R5 random", wr, d, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_add();
    t_take();
    t_collide();
    t_reserved();
    t_saturate();
    t_stall_release();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule